// File: doc/BRIEF.md
# 1-Wire Search Triplet Sequencer

This block carries out one bit position of the 1-Wire ROM search as a single hardware command. A start pulse, together with the branch direction that software would like to take, launches a fixed sequence: two single-bit read slots fetch the id bit and then its complement from the bus, the pair is resolved into a branch decision, and a single-bit write slot sends the chosen direction back so that devices on the other branch drop out. The step ends with a one-cycle done pulse and a 3-bit result code that packs both sampled bits and the direction taken.

The sequencer does not shape bus waveforms itself. It drives a separate bit-slot engine through a request/acknowledge pair: a one-cycle request with a read/write selector and write bit, answered by an acknowledge carrying the captured data word, of which only bit 0 matters. Every slot is guarded by a cycle-count timeout; a missing acknowledge aborts the step with an error flag.

The controller has five states. `ST_IDLE` goes to `ST_RD_ID` on start. `ST_RD_ID` goes to `ST_RD_CMP` on acknowledge. `ST_RD_CMP` goes to `ST_WR_DIR` on acknowledge, or to `ST_FINISH` on acknowledge when neither bit is driven low. `ST_WR_DIR` goes to `ST_FINISH` on acknowledge. Each of the three slot states also goes to `ST_FINISH` on timeout. `ST_FINISH` returns to `ST_IDLE` after one cycle.

Top module: `owt_triplet`

## Requirements
- R1: A start accepted in idle raises a read request (`slot_wr_o`=0) in the next cycle. The order of the slots is read (id bit), then read (complement bit), then write (direction).
- R2: A read result is bit 0 of `slot_rdata_i` in the cycle `slot_ack_i` is high. Bits 7..1 and data in cycles without acknowledge have no effect on the result.
- R3: When the id bit and the complement bit are both 1, the result is 3'b011. No write slot is requested.
- R4: When both bits are 0, the direction written is the `dir_req_i` value latched at start. The result is 3'b100 for direction 1 and 3'b000 for direction 0.
- R5: When exactly one bit is 1, the direction written equals the id bit. The result is 3'b101 for id 1 and 3'b010 for id 0.
- R6: Result field positions: bit 0 is the id bit, bit 1 is the complement bit, bit 2 is the direction taken. Codes 3'b001, 3'b110 and 3'b111 never appear with done.
- R7: If no acknowledge arrives in the TIMEOUT_CYC cycles that begin with a request cycle, the step ends with `done_o` and `err_o` high and result 3'b011. No further slot is requested.
- R8: `start_i` is ignored while `busy_o` is high, including the done cycle. The direction used is the one latched at the accepted start.
- R9: `done_o` and `err_o` last exactly one cycle. `result_o` holds its value until the next step completes.
- R10: After reset the block is idle: `busy_o`, `slot_req_o`, `done_o` and `err_o` are 0, and `result_o` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one search step (sampled in idle only) |
| dir_req_i | input | 1 | Requested branch direction when devices disagree |
| slot_req_o | output | 1 | One-cycle request for a bit slot |
| slot_wr_o | output | 1 | Slot kind: 1 write, 0 read |
| slot_wbit_o | output | 1 | Bit to send in a write slot |
| slot_ack_i | input | 1 | Slot completion from the bit-slot engine |
| slot_rdata_i | input | DATA_W | Captured data; bit 0 is the read bit |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle end-of-step pulse |
| err_o | output | 1 | With done: step aborted by timeout |
| result_o | output | 3 | Result code {direction, complement, id} |

## Verification
The bound checker watches, on every cycle, the rules of sequencing and framing. A start in idle must lead to a read request, done and error are one-cycle pulses, an error always carries code 3'b011, the result never moves outside a done cycle, a done never shows an illegal code, and no slot waits longer than the timeout window. Only the bench's scenarios can show that the decision is right. That means the correct code and written bit for each id/complement/direction combination, the missing write slot when no device answers, the ignoring of the upper data bits and of starts while busy, and the exact acknowledge latency at which the timeout boundary lies.

// File: rtl/owt_pkg.sv
package owt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ID,
        ST_RD_CMP,
        ST_WR_DIR,
        ST_FINISH
    } owt_state_e;

    localparam int unsigned RES_W = 3;

    // result code when no device pulled the line (also used on abort)
    localparam logic [RES_W-1:0] CODE_NO_RESP = 3'b011;

    function automatic logic is_slot_state(input owt_state_e s);
        return (s == ST_RD_ID) || (s == ST_RD_CMP) || (s == ST_WR_DIR);
    endfunction

endpackage

// File: rtl/owt_decide.sv
module owt_decide
    import owt_pkg::*;
(
    input  logic             id_bit,
    input  logic             cmp_bit,
    input  logic             dir_req,
    output logic             no_resp,
    output logic             dir_take,
    output logic [RES_W-1:0] code
);

    always_comb begin
        no_resp  = id_bit & cmp_bit;
        if (id_bit == cmp_bit) begin
            // both low: devices disagree, follow requested path
            // both high: nothing answered, direction is unused and left 0
            dir_take = no_resp ? 1'b0 : dir_req;
        end else begin
            // a single branch present: follow it
            dir_take = id_bit;
        end
        code = {dir_take, cmp_bit, id_bit};
    end

endmodule

// File: rtl/owt_slot_timer.sv
module owt_slot_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // high in the last cycle of the waiting window
    assign expired = (cnt == LAST);

endmodule

// File: rtl/owt_triplet.sv
module owt_triplet
    import owt_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_req_i,
    output logic              slot_req_o,
    output logic              slot_wr_o,
    output logic              slot_wbit_o,
    input  logic              slot_ack_i,
    input  logic [DATA_W-1:0] slot_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [RES_W-1:0]  result_o
);

    owt_state_e st, nxt;

    logic             rd_bit;
    logic             tmo_fire;
    logic             slot_enter;
    logic             expired;
    logic             dec_none, dec_dir;
    logic [RES_W-1:0] dec_code;

    logic             req_q, wr_q, wbit_q, done_q, err_q;
    logic             dir_q, id_q;
    logic [RES_W-1:0] code_q, result_q;

    assign rd_bit = slot_rdata_i[0];

    generate
        if (DATA_W > 1) begin : g_hi_bits
            logic unused_hi;
            assign unused_hi = ^slot_rdata_i[DATA_W-1:1];
        end
    endgenerate

    owt_decide u_decide (
        .id_bit   (id_q),
        .cmp_bit  (rd_bit),
        .dir_req  (dir_q),
        .no_resp  (dec_none),
        .dir_take (dec_dir),
        .code     (dec_code)
    );

    owt_slot_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (slot_enter),
        .run     (is_slot_state(st)),
        .expired (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt      = st;
        tmo_fire = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_i) nxt = ST_RD_ID;
            end
            ST_RD_ID: begin
                if (slot_ack_i) begin
                    nxt = ST_RD_CMP;
                end else if (expired) begin
                    nxt      = ST_FINISH;
                    tmo_fire = 1'b1;
                end
            end
            ST_RD_CMP: begin
                if (slot_ack_i) begin
                    nxt = dec_none ? ST_FINISH : ST_WR_DIR;
                end else if (expired) begin
                    nxt      = ST_FINISH;
                    tmo_fire = 1'b1;
                end
            end
            ST_WR_DIR: begin
                if (slot_ack_i) begin
                    nxt = ST_FINISH;
                end else if (expired) begin
                    nxt      = ST_FINISH;
                    tmo_fire = 1'b1;
                end
            end
            ST_FINISH: begin
                nxt = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    assign slot_enter = is_slot_state(nxt) && (nxt != st);

    // registered outputs and captured step data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            wr_q     <= 1'b0;
            wbit_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            dir_q    <= 1'b0;
            id_q     <= 1'b0;
            code_q   <= '0;
            result_q <= '0;
        end else begin
            req_q  <= slot_enter;
            wr_q   <= (nxt == ST_WR_DIR);
            done_q <= (nxt == ST_FINISH);
            err_q  <= tmo_fire;
            if (st == ST_IDLE && start_i) begin
                dir_q <= dir_req_i;
            end
            if (st == ST_RD_ID && slot_ack_i) begin
                id_q <= rd_bit;
            end
            if (st == ST_RD_CMP && slot_ack_i) begin
                wbit_q <= dec_dir;
                code_q <= dec_code;
            end
            if (nxt == ST_FINISH && st != ST_FINISH) begin
                if (tmo_fire) begin
                    result_q <= CODE_NO_RESP;
                end else if (st == ST_RD_CMP) begin
                    result_q <= dec_code;
                end else begin
                    result_q <= code_q;
                end
            end
        end
    end

    assign slot_req_o  = req_q;
    assign slot_wr_o   = wr_q;
    assign slot_wbit_o = wbit_q;
    assign busy_o      = (st != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign result_o    = result_q;

endmodule

// File: rtl/owt_triplet_chk.sv
module owt_triplet_chk #(
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       slot_req_o,
    input logic       slot_wr_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic [2:0] result_o
);

    localparam int unsigned WW = $clog2(TIMEOUT_CYC + 2) + 1;

    logic [WW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (slot_req_o || !busy_o) begin
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    AST_FIRST_SLOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (slot_req_o && !slot_wr_o)); // R1

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req_o |-> (busy_o && !done_o)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R9

    AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && result_o == 3'b011)); // R7

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (result_o != 3'b001 && result_o != 3'b110 && result_o != 3'b111)); // R6

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (wait_cnt < WW'(TIMEOUT_CYC))); // R7

endmodule

bind owt_triplet owt_triplet_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_owt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .slot_req_o (slot_req_o),
    .slot_wr_o  (slot_wr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .result_o   (result_o)
);

// File: tb/test_owt_triplet.sv
`timescale 1ns/1ps
module test_owt_triplet;

    localparam int TMO = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       dir_req_i = 1'b0;
    logic       slot_req_o, slot_wr_o, slot_wbit_o;
    logic       slot_ack_i = 1'b0;
    logic [7:0] slot_rdata_i = 8'hFF;
    logic       busy_o, done_o, err_o;
    logic [2:0] result_o;

    int nchk = 0;
    int nbad = 0;
    bit finished = 0;

    int         nslots;
    logic       op_wr [4];
    logic       op_wb [4];
    logic       got_done, err_v, done_after, busy_after, req_after;
    logic [2:0] res_v, res_after;

    always #2.5 clk = ~clk;

    owt_triplet #(.DATA_W(8), .TIMEOUT_CYC(TMO)) i_owt_triplet (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .dir_req_i    (dir_req_i),
        .slot_req_o   (slot_req_o),
        .slot_wr_o    (slot_wr_o),
        .slot_wbit_o  (slot_wbit_o),
        .slot_ack_i   (slot_ack_i),
        .slot_rdata_i (slot_rdata_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .result_o     (result_o)
    );

    // fields: dir, id, cmp, ack latency[2:0], upper data bits[6:0], expected code[2:0]
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 3'd1, 7'h7F, 3'b000},
        {1'b1, 1'b0, 1'b0, 3'd2, 7'h55, 3'b100},
        {1'b0, 1'b1, 1'b0, 3'd0, 7'h2A, 3'b101},
        {1'b1, 1'b0, 1'b1, 3'd3, 7'h00, 3'b010},
        {1'b1, 1'b1, 1'b1, 3'd1, 7'h7F, 3'b011},
        {1'b0, 1'b1, 1'b1, 3'd0, 7'h11, 3'b011},
        {1'b1, 1'b1, 1'b0, 3'd7, 7'h3C, 3'b101},
        {1'b0, 1'b0, 1'b1, 3'd5, 7'h66, 3'b010}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // one step with a modelled bit-slot engine; drop = slot index left unanswered
    task automatic run_step(input logic dir, input logic idb, input logic cmpb,
                            input logic [6:0] junk, input int lat, input int drop,
                            input bit glitch, input bit start_on_done);
        int cd;
        cd = -1;
        nslots = 0;
        got_done = 0;
        res_v = '0;
        err_v = 0;
        @(negedge clk);
        start_i = 1'b1;
        dir_req_i = dir;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            slot_ack_i = 1'b0;
            slot_rdata_i = 8'hFF;
            start_i = glitch && (c == 2);
            if (glitch && c == 2) dir_req_i = ~dir;
            if (done_o) begin
                got_done = 1;
                res_v = result_o;
                err_v = err_o;
                if (start_on_done) start_i = 1'b1;
                break;
            end
            if (slot_req_o) begin
                if (nslots < 4) begin
                    op_wr[nslots] = slot_wr_o;
                    op_wb[nslots] = slot_wbit_o;
                end
                cd = (nslots == drop) ? -1 : lat;
                nslots++;
            end else if (cd > 0) begin
                cd--;
            end
            if (cd == 0) begin
                slot_ack_i = 1'b1;
                slot_rdata_i = {junk, (nslots == 1) ? idb : cmpb};
                cd = -1;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        slot_ack_i = 1'b0;
        done_after = done_o;
        res_after = result_o;
        busy_after = busy_o;
        req_after = slot_req_o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy_o && !slot_req_o && !done_o && !err_o, "R10 idle flags", {busy_o, slot_req_o, done_o, err_o}, 0);
        check(result_o == 3'b000, "R10 result", result_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VEC[i]) begin
            logic       d, idb, cb;
            logic [2:0] ex;
            int         ns;
            string      tg;
            d   = VEC[i][15];
            idb = VEC[i][14];
            cb  = VEC[i][13];
            ex  = VEC[i][2:0];
            ns  = (idb && cb) ? 2 : 3;
            tg  = (idb && cb) ? "R3" : ((idb == cb) ? "R4" : "R5");
            run_step(d, idb, cb, VEC[i][9:3], int'(VEC[i][12:10]), 9, 1'b0, 1'b0);
            check(got_done && !err_v, {tg, " done no err"}, {got_done, err_v}, 2);
            check(res_v == ex, {tg, " code"}, res_v, ex);
            check(nslots == ns, {tg, " slot count"}, nslots, ns);
            check(!op_wr[0] && !op_wr[1], "R1 two reads first", {op_wr[0], op_wr[1]}, 0);
            if (ns == 3) begin
                check(op_wr[2] && op_wb[2] == ex[2], {tg, " write slot bit"}, {op_wr[2], op_wb[2]}, {1'b1, ex[2]});
            end
            check(res_v[0] == idb && res_v[1] == cb, "R2 R6 sampled bits in code", res_v[1:0], {cb, idb});
            check(!done_after && res_after == ex, "R9 done pulse and hold", {done_after, res_after}, ex);
        end

        // R7 timeout in each slot; latency 8 exceeds the window too
        for (int s = 0; s < 3; s++) begin
            run_step(1'b0, 1'b0, 1'b0, 7'h00, 1, s, 1'b0, 1'b0);
            check(got_done && err_v && res_v == 3'b011, "R7 abort code", {got_done, err_v, res_v}, 6'b11011);
            check(nslots == s + 1, "R7 no later slot", nslots, s + 1);
            check(!done_after, "R9 err pulse single", done_after, 0);
        end
        run_step(1'b1, 1'b0, 1'b0, 7'h00, 8, 9, 1'b0, 1'b0);
        check(err_v && nslots == 1, "R7 late ack", {err_v, 4'(nslots)}, 5'b10001);

        // R8 start mid-step with flipped direction, and start in the done cycle
        run_step(1'b0, 1'b0, 1'b0, 7'h7F, 2, 9, 1'b1, 1'b1);
        check(res_v == 3'b000 && nslots == 3, "R8 latched direction", {res_v, 4'(nslots)}, 3);
        check(!busy_after && !req_after, "R8 start in done cycle ignored", {busy_after, req_after}, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule